// File: doc/BRIEF.md
# Block-Partitioned SEC-DED Protected Memory

This block is a storage array whose rows each hold several data words. Every word is cut into equal data blocks, and every block is stored with its own check bits, so a soft error costs at most one block's worth of correction logic. The code is chosen at build time: no protection, even parity, single-error-correcting Hamming, or Hamming with an extra overall parity bit for double-error detection. Writes encode the incoming row and update only the words selected by a word mask. Reads decode every block, return the corrected row one cycle later, and raise a corrected-error flag and an uncorrectable-error flag.

Optionally the stored bits of all blocks in a row are shuffled, so that neighbouring physical cells belong to different blocks and a burst upset of adjacent cells turns into several correctable single errors. Corrected rows are offered, with their address, on a separate output for a later write-back stage. Saturating counters keep running totals of delivered reads, accepted writes, flagged reads and corrected blocks. A cancel input, raised in the response cycle, discards a read that turned out to target data never written, so that it neither flags nor counts.

Write and read requests are valid/ready streams. The write stream is always ready. The read stream is always ready in dual-port builds; in single-port builds a read is refused (ready low) in any cycle where a write is offered, and the requester must hold it. The read response and the correction output are fixed-latency and cannot be stalled: the consumer must take them in the cycle they are valid. A fault-insertion mask on the write stream flips chosen stored bits of the row being written, for exercising the code.

Top module: `ecc_row_mem`

## Requirements
- R1: A read accepted at a clock edge produces rsp_valid for exactly one cycle after that edge, with rsp_data equal to the last data written to each word of that row.
- R2: A write updates only the words whose wr_mask bit is set; word w occupies bits [w*WORD_W +: WORD_W] of the row, block b of the row occupies data bits [b*BLK_W +: BLK_W].
- R3: With the SEC-DED code, a single flipped stored bit in a block returns the original data with rsp_serr high and rsp_derr low.
- R4: With the SEC-DED code, two flipped stored bits in one block give rsp_derr high and no correction output.
- R5: With interleaving on, physical stored bit p belongs to block p mod NBLK at codeword bit p div NBLK, so flips in any two adjacent physical bits land in different blocks and are both corrected.
- R6: A response with rsp_serr high and rsp_derr low also raises fix_valid with fix_addr equal to the read address, fix_data equal to the corrected row, and fix_words marking every word that held a corrected block.
- R7: Raising rd_kill in the response cycle suppresses rsp_valid, both error flags and fix_valid, and leaves every counter unchanged.
- R8: Every counter stops at its all-ones value and never wraps.
- R9: cnt_rd counts delivered responses, cnt_wr accepted writes, cnt_serr and cnt_derr responses carrying each flag, and cnt_fix the number of corrected blocks.
- R10: With the parity code and no interleaving, block b occupies stored bits [b*CW +: CW] laid out as {check, data}; one flipped bit yields rsp_derr high, rsp_serr low, and the data returned unchanged from storage.
- R11: In a single-port build rd_ready is low while wr_valid is high; in a dual-port build a read and write to the same row in one cycle both proceed and the read returns the previous contents.
- R12: Fault-insertion bits in wr_inj that fall on words not selected by wr_mask have no effect.
- R13: After reset all counters read zero and no response or correction is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted |
| wr_addr | input | AW | Write row address |
| wr_data | input | ROW_W | Write row data |
| wr_mask | input | WORDS | Per-word write enable |
| wr_inj | input | PHY_W | Stored-bit flip mask for fault insertion |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_addr | input | AW | Read row address |
| rd_kill | input | 1 | Cancel the read whose response is due this cycle |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | ROW_W | Corrected read row |
| rsp_serr | output | 1 | At least one block was corrected |
| rsp_derr | output | 1 | At least one block is uncorrectable |
| fix_valid | output | 1 | Corrected row available for write-back |
| fix_addr | output | AW | Row address of the corrected row |
| fix_data | output | ROW_W | Corrected row data |
| fix_words | output | WORDS | Words holding a corrected block |
| cnt_serr | output | CNT_W | Responses with a corrected error |
| cnt_derr | output | CNT_W | Responses with an uncorrectable error |
| cnt_rd | output | CNT_W | Delivered read responses |
| cnt_wr | output | CNT_W | Accepted writes |
| cnt_fix | output | CNT_W | Corrected blocks |

## Verification
A wrong bit-to-block mapping or a broken syndrome decoder shows up on the very next response after a write with a single inserted flip: either the data comes back altered, or the flags and fix_words name the wrong word. Every physical bit position is flipped alone, in adjacent pairs and in same-block pairs, so any misplaced wire is seen within one read. Counter faults appear on the count outputs one cycle after the offending response, and a kill that leaks shows as a counter step or a stray rsp_valid in that same cycle.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;

  typedef enum logic [1:0] {
    ECC_OFF = 2'd0,
    ECC_PAR = 2'd1,
    ECC_SEC = 2'd2,
    ECC_DED = 2'd3
  } ecc_code_e;

  // Hamming check bits needed for k data bits
  function automatic int ham_r(input int k);
    int r;
    r = 1;
    while ((1 << r) < k + r + 1) r++;
    return r;
  endfunction

  // Total check bits a block carries under a given code
  function automatic int chk_w(input ecc_code_e c, input int k);
    case (c)
      ECC_OFF: return 0;
      ECC_PAR: return 1;
      ECC_SEC: return ham_r(k);
      default: return ham_r(k) + 1;
    endcase
  endfunction

  // Hamming position (1-based, powers of two reserved) of data bit i
  function automatic int ham_pos(input int i);
    int p;
    int n;
    p = 2;
    n = -1;
    while (n < i) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

endpackage

// File: rtl/ecc_blk_enc.sv
module ecc_blk_enc
  import ecc_mem_pkg::*;
#(
  parameter ecc_code_e CODE = ECC_DED,
  parameter int        K    = 8
) (
  input  logic [K-1:0]                  data,
  output logic [K+chk_w(CODE,K)-1:0]    cw
);
  localparam int R = ham_r(K);

  function automatic logic [K-1:0] col_mask(input int j);
    logic [K-1:0] m;
    for (int i = 0; i < K; i++) m[i] = ((ham_pos(i) >> j) & 1) == 1;
    return m;
  endfunction

  generate
    if (CODE == ECC_OFF) begin : g_off
      assign cw = data;
    end else if (CODE == ECC_PAR) begin : g_par
      assign cw = {^data, data};
    end else begin : g_ham
      logic [R-1:0] h;
      for (genvar j = 0; j < R; j++) begin : g_col
        localparam logic [K-1:0] MJ = col_mask(j);
        assign h[j] = ^(data & MJ);
      end
      if (CODE == ECC_DED) begin : g_ded
        assign cw = {^{h, data}, h, data};
      end else begin : g_sec
        assign cw = {h, data};
      end
    end
  endgenerate
endmodule

// File: rtl/ecc_blk_dec.sv
module ecc_blk_dec
  import ecc_mem_pkg::*;
#(
  parameter ecc_code_e CODE = ECC_DED,
  parameter int        K    = 8
) (
  input  logic [K+chk_w(CODE,K)-1:0]    cw,
  output logic [K-1:0]                  data,
  output logic                          sgl,
  output logic                          dbl
);
  localparam int R = ham_r(K);

  function automatic logic [K-1:0] col_mask(input int j);
    logic [K-1:0] m;
    for (int i = 0; i < K; i++) m[i] = ((ham_pos(i) >> j) & 1) == 1;
    return m;
  endfunction

  generate
    if (CODE == ECC_OFF) begin : g_off
      assign data = cw;
      assign sgl  = 1'b0;
      assign dbl  = 1'b0;
    end else if (CODE == ECC_PAR) begin : g_par
      assign data = cw[K-1:0];
      assign sgl  = 1'b0;
      assign dbl  = ^cw;
    end else begin : g_ham
      localparam bit DED = (CODE == ECC_DED);
      logic [R-1:0] syn;
      logic [K-1:0] flip;
      logic         odd;
      logic         hit;
      logic         inrange;
      logic         corr;

      for (genvar j = 0; j < R; j++) begin : g_col
        localparam logic [K-1:0] MJ = col_mask(j);
        assign syn[j] = cw[K+j] ^ (^(cw[K-1:0] & MJ));
      end

      if (DED) begin : g_odd
        assign odd = ^cw;
      end else begin : g_noodd
        assign odd = 1'b1;
      end

      assign hit     = |syn;
      assign inrange = int'(syn) <= (K + R);
      assign corr    = hit && odd && inrange;
      assign sgl     = corr || (DED && !hit && odd);
      assign dbl     = hit && !(odd && inrange);

      for (genvar i = 0; i < K; i++) begin : g_flip
        localparam int P = ham_pos(i);
        assign flip[i] = corr && (int'(syn) == P);
      end
      assign data = cw[K-1:0] ^ flip;
    end
  endgenerate
endmodule

// File: rtl/ecc_sat_cnt.sv
module ecc_sat_cnt #(
  parameter int W  = 8,
  parameter int AW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  cnt
);
  localparam int SW = ((W > AW) ? W : AW) + 1;
  localparam logic [SW-1:0] TOP = {{(SW-W){1'b0}}, {W{1'b1}}};

  logic [SW-1:0] sum;
  assign sum = SW'(cnt) + SW'(amt);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= (sum > TOP) ? '1 : sum[W-1:0];
  end

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1) |=> (cnt == '1));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (amt == '0) |=> $stable(cnt));
endmodule

// File: rtl/ecc_row_mem.sv
module ecc_row_mem
  import ecc_mem_pkg::*;
#(
  parameter ecc_code_e CODE        = ECC_DED,
  parameter int        DEPTH       = 8,
  parameter int        WORDS       = 2,
  parameter int        WORD_W      = 16,
  parameter int        BLK_W       = 8,
  parameter bit        INTERLEAVE  = 1'b1,
  parameter bit        SINGLE_PORT = 1'b0,
  parameter int        CNT_W       = 8,
  localparam int       AW          = $clog2(DEPTH),
  localparam int       ROW_W       = WORDS * WORD_W,
  localparam int       NBLK        = WORDS * (WORD_W / BLK_W),
  localparam int       PHY_W       = NBLK * (BLK_W + chk_w(CODE, BLK_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [ROW_W-1:0]  wr_data,
  input  logic [WORDS-1:0]  wr_mask,
  input  logic [PHY_W-1:0]  wr_inj,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_kill,
  output logic              rsp_valid,
  output logic [ROW_W-1:0]  rsp_data,
  output logic              rsp_serr,
  output logic              rsp_derr,
  output logic              fix_valid,
  output logic [AW-1:0]     fix_addr,
  output logic [ROW_W-1:0]  fix_data,
  output logic [WORDS-1:0]  fix_words,
  output logic [CNT_W-1:0]  cnt_serr,
  output logic [CNT_W-1:0]  cnt_derr,
  output logic [CNT_W-1:0]  cnt_rd,
  output logic [CNT_W-1:0]  cnt_wr,
  output logic [CNT_W-1:0]  cnt_fix
);
  localparam int BPW = WORD_W / BLK_W;
  localparam int CW  = BLK_W + chk_w(CODE, BLK_W);
  localparam int FW  = $clog2(NBLK + 1);

  logic [PHY_W-1:0] mem [DEPTH];
  logic [PHY_W-1:0] enc_log, enc_phy;
  logic [PHY_W-1:0] en_log, en_phy;
  logic [PHY_W-1:0] raw_q, raw_log;
  logic [ROW_W-1:0] cor_row;
  logic [NBLK-1:0]  blk_sgl, blk_dbl;
  logic [AW-1:0]    rd_addr_q;
  logic             rd_pend;
  logic             wr_fire, rd_fire;
  logic [FW-1:0]    fix_amt;

  // request side handshakes
  assign wr_ready = 1'b1;
  generate
    if (SINGLE_PORT) begin : g_sp
      assign rd_ready = !wr_valid;
    end else begin : g_dp
      assign rd_ready = 1'b1;
    end
  endgenerate
  assign wr_fire = wr_valid && wr_ready;
  assign rd_fire = rd_valid && rd_ready;

  // per-block coding and the logical-to-physical bit map
  generate
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
      ecc_blk_enc #(.CODE(CODE), .K(BLK_W)) u_enc (
        .data (wr_data[b*BLK_W +: BLK_W]),
        .cw   (enc_log[b*CW +: CW])
      );
      ecc_blk_dec #(.CODE(CODE), .K(BLK_W)) u_dec (
        .cw   (raw_log[b*CW +: CW]),
        .data (cor_row[b*BLK_W +: BLK_W]),
        .sgl  (blk_sgl[b]),
        .dbl  (blk_dbl[b])
      );
      assign en_log[b*CW +: CW] = {CW{wr_mask[b / BPW]}};
      for (genvar j = 0; j < CW; j++) begin : g_bit
        localparam int PHY = INTERLEAVE ? (j * NBLK + b) : (b * CW + j);
        assign enc_phy[PHY]     = enc_log[b*CW + j];
        assign en_phy[PHY]      = en_log[b*CW + j];
        assign raw_log[b*CW + j] = raw_q[PHY];
      end
    end
  endgenerate

  // storage: bit-enabled merge on write, registered read (read-first)
  always_ff @(posedge clk) begin
    if (wr_fire)
      mem[wr_addr] <= (mem[wr_addr] & ~en_phy) | ((enc_phy ^ wr_inj) & en_phy);
    if (rd_fire) begin
      raw_q     <= mem[rd_addr];
      rd_addr_q <= rd_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= rd_fire;
  end

  // response and correction outputs
  assign rsp_valid = rd_pend && !rd_kill;
  assign rsp_data  = cor_row;
  assign rsp_serr  = rsp_valid && (|blk_sgl);
  assign rsp_derr  = rsp_valid && (|blk_dbl);
  assign fix_valid = rsp_serr && !rsp_derr;
  assign fix_addr  = rd_addr_q;
  assign fix_data  = cor_row;
  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_fixw
      assign fix_words[w] = fix_valid && (|blk_sgl[w*BPW +: BPW]);
    end
  endgenerate
  assign fix_amt = rsp_valid ? FW'($countones(blk_sgl)) : '0;

  // statistics
  ecc_sat_cnt #(.W(CNT_W), .AW(1)) u_cnt_serr (
    .clk(clk), .rst_n(rst_n), .amt(rsp_serr), .cnt(cnt_serr));
  ecc_sat_cnt #(.W(CNT_W), .AW(1)) u_cnt_derr (
    .clk(clk), .rst_n(rst_n), .amt(rsp_derr), .cnt(cnt_derr));
  ecc_sat_cnt #(.W(CNT_W), .AW(1)) u_cnt_rd (
    .clk(clk), .rst_n(rst_n), .amt(rsp_valid), .cnt(cnt_rd));
  ecc_sat_cnt #(.W(CNT_W), .AW(1)) u_cnt_wr (
    .clk(clk), .rst_n(rst_n), .amt(wr_fire), .cnt(cnt_wr));
  ecc_sat_cnt #(.W(CNT_W), .AW(FW)) u_cnt_fix (
    .clk(clk), .rst_n(rst_n), .amt(fix_amt), .cnt(cnt_fix));

  p_rsp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_valid && rd_ready));

  p_fix_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid |-> (fix_addr == $past(rd_addr)));

  p_kill_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_kill |=> ($stable(cnt_rd) && $stable(cnt_serr) && $stable(cnt_derr) && $stable(cnt_fix)));

  p_wr_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && (cnt_wr != '1)) |=> (cnt_wr == CNT_W'($past(cnt_wr) + 1'b1)));
endmodule

// File: tb/sim_ecc_row_mem.sv
`timescale 1ns/1ps
module sim_ecc_row_mem;
  import ecc_mem_pkg::*;

  localparam int PW0 = 52;  // 4 blocks x 13 bits (SEC-DED, 8 data bits)
  localparam int PW1 = 36;  // 4 blocks x 9 bits (parity)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // u0 signals
  logic w0_v = 0, r0_v = 0, k0 = 0;
  logic w0_r, r0_r;
  logic [2:0] w0_a = 0, r0_a = 0;
  logic [31:0] w0_d = 0;
  logic [1:0] w0_m = 0;
  logic [PW0-1:0] w0_i = 0;
  logic s0_v, s0_se, s0_de, f0_v;
  logic [31:0] s0_d, f0_d;
  logic [2:0] f0_a;
  logic [1:0] f0_w;
  logic [3:0] c0_se, c0_de, c0_rd, c0_wr, c0_fx;

  // u1 signals
  logic w1_v = 0, r1_v = 0, k1 = 0;
  logic w1_r, r1_r;
  logic [2:0] w1_a = 0, r1_a = 0;
  logic [31:0] w1_d = 0;
  logic [1:0] w1_m = 0;
  logic [PW1-1:0] w1_i = 0;
  logic s1_v, s1_se, s1_de, f1_v;
  logic [31:0] s1_d, f1_d;
  logic [2:0] f1_a;
  logic [1:0] f1_w;
  logic [3:0] c1_se, c1_de, c1_rd, c1_wr, c1_fx;

  ecc_row_mem #(.CODE(ECC_DED), .DEPTH(8), .WORDS(2), .WORD_W(16), .BLK_W(8),
                .INTERLEAVE(1'b1), .SINGLE_PORT(1'b0), .CNT_W(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(w0_v), .wr_ready(w0_r), .wr_addr(w0_a), .wr_data(w0_d),
    .wr_mask(w0_m), .wr_inj(w0_i),
    .rd_valid(r0_v), .rd_ready(r0_r), .rd_addr(r0_a), .rd_kill(k0),
    .rsp_valid(s0_v), .rsp_data(s0_d), .rsp_serr(s0_se), .rsp_derr(s0_de),
    .fix_valid(f0_v), .fix_addr(f0_a), .fix_data(f0_d), .fix_words(f0_w),
    .cnt_serr(c0_se), .cnt_derr(c0_de), .cnt_rd(c0_rd), .cnt_wr(c0_wr), .cnt_fix(c0_fx));

  ecc_row_mem #(.CODE(ECC_PAR), .DEPTH(8), .WORDS(2), .WORD_W(16), .BLK_W(8),
                .INTERLEAVE(1'b0), .SINGLE_PORT(1'b1), .CNT_W(4)) u1 (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(w1_v), .wr_ready(w1_r), .wr_addr(w1_a), .wr_data(w1_d),
    .wr_mask(w1_m), .wr_inj(w1_i),
    .rd_valid(r1_v), .rd_ready(r1_r), .rd_addr(r1_a), .rd_kill(k1),
    .rsp_valid(s1_v), .rsp_data(s1_d), .rsp_serr(s1_se), .rsp_derr(s1_de),
    .fix_valid(f1_v), .fix_addr(f1_a), .fix_data(f1_d), .fix_words(f1_w),
    .cnt_serr(c1_se), .cnt_derr(c1_de), .cnt_rd(c1_rd), .cnt_wr(c1_wr), .cnt_fix(c1_fx));

  // expected counter model (saturating at 15)
  int e_wr = 0, e_rd = 0, e_s = 0, e_d = 0, e_fx = 0;
  int g_wr = 0, g_rd = 0, g_d = 0;

  function automatic int sinc(input int v, input int a);
    return (v + a > 15) ? 15 : v + a;
  endfunction

  function automatic logic [31:0] rowdat(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr0(input int a, input logic [31:0] d, input logic [1:0] m,
                     input logic [PW0-1:0] inj);
    @(negedge clk);
    w0_v = 1; w0_a = 3'(a); w0_d = d; w0_m = m; w0_i = inj;
    @(negedge clk);
    w0_v = 0; w0_i = '0;
    e_wr = sinc(e_wr, 1);
  endtask

  task automatic rd0(input int a, input bit kill);
    @(negedge clk);
    r0_v = 1; r0_a = 3'(a);
    @(negedge clk);
    r0_v = 0; k0 = kill;
    #1;
  endtask

  task automatic end0;
    @(negedge clk);
    k0 = 0;
  endtask

  task automatic acct0(input bit se, input bit de, input int fx);
    e_rd = sinc(e_rd, 1);
    if (se) e_s = sinc(e_s, 1);
    if (de) e_d = sinc(e_d, 1);
    e_fx = sinc(e_fx, fx);
  endtask

  task automatic chkcnt0(input string req);
    chk(req, 64'(c0_wr), 64'(e_wr));
    chk(req, 64'(c0_rd), 64'(e_rd));
    chk(req, 64'(c0_se), 64'(e_s));
    chk(req, 64'(c0_de), 64'(e_d));
    chk(req, 64'(c0_fx), 64'(e_fx));
  endtask

  task automatic wr1(input int a, input logic [31:0] d, input logic [PW1-1:0] inj);
    @(negedge clk);
    w1_v = 1; w1_a = 3'(a); w1_d = d; w1_m = 2'b11; w1_i = inj;
    @(negedge clk);
    w1_v = 0; w1_i = '0;
    g_wr = sinc(g_wr, 1);
  endtask

  task automatic rd1(input int a);
    @(negedge clk);
    r1_v = 1; r1_a = 3'(a);
    @(negedge clk);
    r1_v = 0;
    #1;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] dd;
    logic [PW0-1:0] one0;
    logic [PW1-1:0] one1;
    logic [PW0-1:0] ig;
    one0 = 1;
    one1 = 1;

    repeat (4) @(negedge clk);
    // R13: reset state
    #1;
    chk("R13 rsp_valid", 64'(s0_v), 64'd0);
    chk("R13 fix_valid", 64'(f0_v), 64'd0);
    chkcnt0("R13 counters");
    chk("R13 u1 cnt_rd", 64'(c1_rd), 64'd0);
    @(negedge clk);
    rst_n = 1;

    // R1: round trip over every row
    for (int a = 0; a < 8; a++) wr0(a, rowdat(a), 2'b11, '0);
    for (int a = 0; a < 8; a++) begin
      rd0(a, 0);
      chk("R1 valid", 64'(s0_v), 64'd1);
      chk("R1 data", 64'(s0_d), 64'(rowdat(a)));
      chk("R1 flags", 64'({s0_se, s0_de}), 64'd0);
      end0();
      acct0(0, 0, 0);
      #1;
      chk("R1 single-cycle valid", 64'(s0_v), 64'd0);
    end
    chkcnt0("R9 counts after sweep");

    // R2: word mask
    wr0(3, 32'hCAFEF00D, 2'b01, '0);
    wr0(4, 32'hBEEF1234, 2'b10, '0);
    rd0(3, 0);
    chk("R2 low word", 64'(s0_d), 64'({rowdat(3)[31:16], 16'hF00D}));
    end0(); acct0(0, 0, 0);
    rd0(4, 0);
    chk("R2 high word", 64'(s0_d), 64'({16'hBEEF, rowdat(4)[15:0]}));
    end0(); acct0(0, 0, 0);

    // R11: dual-port same row same cycle reads old contents
    @(negedge clk);
    w0_v = 1; w0_a = 3'd1; w0_d = 32'h600DD00D; w0_m = 2'b11;
    r0_v = 1; r0_a = 3'd1;
    #1;
    chk("R11 dual rd_ready", 64'(r0_r), 64'd1);
    @(negedge clk);
    w0_v = 0; r0_v = 0;
    #1;
    e_wr = sinc(e_wr, 1);
    chk("R11 old data", 64'(s0_d), 64'(rowdat(1)));
    end0(); acct0(0, 0, 0);
    rd0(1, 0);
    chk("R11 new data", 64'(s0_d), 64'h600DD00D);
    end0(); acct0(0, 0, 0);
    chkcnt0("R9 counts before kill");

    // R7: kill suppresses a read that would flag
    wr0(7, 32'h7777AAAA, 2'b11, one0);
    rd0(7, 1);
    chk("R7 no valid", 64'(s0_v), 64'd0);
    chk("R7 no flags", 64'({s0_se, s0_de, f0_v}), 64'd0);
    end0();
    chkcnt0("R7 counters held");
    rd0(7, 0);
    chk("R7 unkilled corrects", 64'({s0_se, s0_de}), 64'b10);
    chk("R7 unkilled data", 64'(s0_d), 64'h7777AAAA);
    end0(); acct0(1, 0, 1);
    chkcnt0("R9 counts after one fix");

    // R3 R5 R6: every single stored-bit flip
    for (int p = 0; p < PW0; p++) begin
      dd = 32'h0F1E2D3C ^ 32'(p * 32'h01010101);
      wr0(5, dd, 2'b11, one0 << p);
      rd0(5, 0);
      chk("R3 data", 64'(s0_d), 64'(dd));
      chk("R3 flags", 64'({s0_se, s0_de}), 64'b10);
      chk("R6 fix", 64'({f0_v, f0_a, f0_d}), 64'({1'b1, 3'd5, dd}));
      chk("R5 fix_words", 64'(f0_w), 64'(2'b01 << ((p % 4) / 2)));
      end0(); acct0(1, 0, 1);
    end

    // R4: two flips in the same block
    for (int p = 0; p < PW0 - 4; p++) begin
      wr0(2, rowdat(p), 2'b11, (one0 << p) | (one0 << (p + 4)));
      rd0(2, 0);
      chk("R4 flags", 64'({s0_se, s0_de}), 64'b01);
      chk("R4 no fix", 64'(f0_v), 64'd0);
      end0(); acct0(0, 1, 0);
    end

    // R5: adjacent physical flips land in different blocks
    for (int p = 0; p < PW0 - 1; p++) begin
      dd = rowdat(p + 40);
      wr0(0, dd, 2'b11, (one0 << p) | (one0 << (p + 1)));
      rd0(0, 0);
      chk("R5 data", 64'(s0_d), 64'(dd));
      chk("R5 flags", 64'({s0_se, s0_de}), 64'b10);
      chk("R5 words", 64'(f0_w),
          64'((2'b01 << ((p % 4) / 2)) | (2'b01 << (((p + 1) % 4) / 2))));
      end0(); acct0(1, 0, 2);
    end

    // R12: injection onto an unselected word is ignored
    ig = '0;
    for (int p = 0; p < PW0; p++) if ((p % 4) < 2) ig[p] = 1'b1;
    wr0(6, 32'h5151A0A0, 2'b10, ig);
    rd0(6, 0);
    chk("R12 flags", 64'({s0_se, s0_de}), 64'd0);
    chk("R12 data", 64'(s0_d), 64'({16'h5151, rowdat(6)[15:0]}));
    end0(); acct0(0, 0, 0);

    // R8: saturation
    #1;
    chkcnt0("R8 saturated counters");
    chk("R8 rd at max", 64'(c0_rd), 64'd15);
    chk("R8 fix at max", 64'(c0_fx), 64'd15);

    // u1: R11 single-port exclusion
    @(negedge clk);
    w1_v = 1; w1_a = 3'd0; w1_d = 32'h11112222; w1_m = 2'b11;
    r1_v = 1; r1_a = 3'd0;
    #1;
    chk("R11 sp rd_ready", 64'(r1_r), 64'd0);
    chk("R11 sp wr_ready", 64'(w1_r), 64'd1);
    @(negedge clk);
    w1_v = 0; r1_v = 0;
    g_wr = sinc(g_wr, 1);
    #1;
    chk("R11 sp no response", 64'(s1_v), 64'd0);
    rd1(0);
    chk("R11 sp data", 64'(s1_d), 64'h11112222);
    chk("R10 clean parity", 64'({s1_se, s1_de}), 64'd0);
    g_rd = sinc(g_rd, 1);

    // R10: parity, every stored bit
    for (int p = 0; p < PW1; p++) begin
      dd = 32'h89AB4567 ^ 32'(p * 32'h00130013);
      wr1(2, dd, one1 << p);
      rd1(2);
      chk("R10 flags", 64'({s1_se, s1_de, f1_v}), 64'b010);
      if ((p % 9) < 8) dd[(p / 9) * 8 + (p % 9)] = ~dd[(p / 9) * 8 + (p % 9)];
      chk("R10 raw data", 64'(s1_d), 64'(dd));
      g_rd = sinc(g_rd, 1);
      g_d = sinc(g_d, 1);
    end
    @(negedge clk);
    chk("R9 u1 derr", 64'(c1_de), 64'(g_d));
    chk("R9 u1 rd", 64'(c1_rd), 64'(g_rd));
    chk("R9 u1 wr", 64'(c1_wr), 64'(g_wr));
    chk("R9 u1 serr", 64'(c1_se), 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule